// File: doc/BRIEF.md
# Packet Drop Monitor

This block sits at the end of a receive packet filter. Each cycle, the earlier filter stages may present one packet. With it come their verdicts: VLAN membership failed, a TCAM result asked for a drop, or the class code asked for a drop. The packet also carries a destination-address match flag, a bad-checksum flag and its six TCP control flags. The block forms a fifth drop reason by masking the TCP flags with a programmed set, OR-reducing them and qualifying the result with a discard enable. It then drives the final drop decision for the packet.

For software, the block keeps a one-shot drop log. The log records the reason bits of the first drop that is not excluded by the log mask. It stays frozen until software clears the packet-drop interrupt status bit, and that clear re-arms it. Three interrupt status bits can be cleared by writing 1 and can also be set from a debug register. These bits drive a maskable interrupt line. Two address logs record the first parity-error address reported for the VLAN table and for the TCAM result table. Two saturating clear-on-read counters count dropped packets and bad checksums, but only for packets whose destination address matched.

Register access is a simple word-addressed port. A write takes effect at the clock edge. Read data appears on `reg_rdata_o` in the cycle after `reg_rd_i` is high.

Top module: `pkt_drop_monitor`

## Requirements
- R1: `drop_o` is high, in the same cycle, exactly when `pkt_valid_i` is high and at least one of the five reasons holds. The reasons are `vlan_miss_i`, `tcam_drop_i`, `class_drop_i`, low `l2_match_i`, and the TCP reason.
- R2: The TCP reason holds when bit 6 (discard) of the TCP config register (address 4) is 1 and any flag in `tcp_flags_i` is set together with the same bit of the config field [5:0]. Flags are URG bit 0, ACK 1, PSH 2, RST 3, SYN 4, FIN 5.
- R3: Reason vector bits are VLAN 0, TCAM 1, class 2, address mismatch 3, TCP 4. A packet whose reasons ANDed with the inverse of the log mask (address 3, bit i masks reason i) is nonzero is a capture. If status bit 2 is clear, a capture stores that masked vector in the drop log (address 5, bits [4:0]) and sets status bit 2.
- R4: While status bit 2 is set, the drop log does not change. Clearing status bit 2 clears the log to 0 and re-arms it.
- R5: Status (address 0) has bit 0 for VLAN parity error, bit 1 for TCAM parity error and bit 2 for packet drop. Writing 1 to a bit clears it. A set event in the same cycle overrides the clear.
- R6: Writing 1 to a bit of the debug register (address 1) sets the matching status bit.
- R7: `irq_o` is high when any status bit is set whose interrupt mask bit (address 2, 1 = masked) is 0.
- R8: A parity error pulse with its status bit clear stores its address in the error log (address 6): the VLAN address in bits [11:0] and the TCAM address in bits [23:16]. Later errors leave the log unchanged. Clearing the status bit clears that field.
- R9: The drop counter (address 7) counts dropped packets with `l2_match_i` high. The bad-checksum counter (address 8) counts valid packets with both `l2_match_i` and `bad_csum_i` high.
- R10: Reading a counter returns its value and clears it. An increment in the same cycle as the read leaves the counter at 1.
- R11: The counters hold at all ones instead of wrapping.
- R12: After reset, all registers, logs and counters read 0 and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkt_valid_i | input | 1 | Packet verdict strobe |
| vlan_miss_i | input | 1 | Not a VLAN member |
| tcam_drop_i | input | 1 | TCAM result asks for drop |
| class_drop_i | input | 1 | Class code asks for drop |
| l2_match_i | input | 1 | Destination address matched |
| bad_csum_i | input | 1 | TCP/UDP checksum bad |
| tcp_flags_i | input | 6 | TCP control flags |
| vlan_perr_i | input | 1 | VLAN table parity error pulse |
| vlan_perr_addr_i | input | VLAN_AW | Failing VLAN table address |
| tcam_perr_i | input | 1 | TCAM result table parity error pulse |
| tcam_perr_addr_i | input | TCAM_AW | Failing TCAM result address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, one cycle after the read |
| drop_o | output | 1 | Final drop decision |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench builds the block with 4-bit counters. This puts saturation within reach after fifteen counted events, so the hold-at-all-ones behaviour and the read-with-increment collision are checked directly. Table address widths keep their defaults of 12 and 8, so the two error-log fields are checked at their full widths and positions. A fixed-seed random phase mixes reasons, masks, address mismatch and re-arm writes against a bench model of the log and counters.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  localparam int NUM_RSN  = 5;
  localparam int RSN_VLAN = 0;
  localparam int RSN_TCAM = 1;
  localparam int RSN_CLS  = 2;
  localparam int RSN_L2   = 3;
  localparam int RSN_TCP  = 4;

  localparam int NUM_ST       = 3;
  localparam int ST_VLAN_PERR = 0;
  localparam int ST_TCAM_PERR = 1;
  localparam int ST_DROP      = 2;

  localparam int TCP_FLAG_W = 6;

  localparam int RA_STATUS = 0;
  localparam int RA_DEBUG  = 1;
  localparam int RA_IRQMSK = 2;
  localparam int RA_LOGMSK = 3;
  localparam int RA_TCPCFG = 4;
  localparam int RA_LOG    = 5;
  localparam int RA_PERR   = 6;
  localparam int RA_DCNT   = 7;
  localparam int RA_BCNT   = 8;
  localparam int NUM_CNT   = 2;
endpackage

// File: rtl/pdm_tcp_check.sv
module pdm_tcp_check #(
  parameter int FLAG_W = 6
) (
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [FLAG_W-1:0] mask_i,
  input  logic              discard_i,
  output logic              hit_o
);
  assign hit_o = discard_i & (|(flags_i & mask_i));
endmodule

// File: rtl/pdm_first_log.sv
module pdm_first_log #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic         armed_i,
  input  logic         clr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] log_o
);
  logic [W-1:0] log_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                log_q <= '0;
    else if (cap_i && armed_i)  log_q <= data_i;
    else if (clr_i)             log_q <= '0;
  end

  assign log_o = log_q;

  // R4 / R8: a disarmed log only moves on a clear
  p_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_i && !clr_i) |=> $stable(log_q));
endmodule

// File: rtl/pdm_sat_cnt.sv
module pdm_sat_cnt #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= inc_i ? W'(1) : '0;
    else if (inc_i && cnt_q != MAX) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;

  p_sat_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX && !clr_i) |=> cnt_q == MAX);
  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !inc_i) |=> cnt_q == '0);
endmodule

// File: rtl/pkt_drop_monitor.sv
module pkt_drop_monitor
  import pdm_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int VLAN_AW = 12,
  parameter int TCAM_AW = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  pkt_valid_i,
  input  logic                  vlan_miss_i,
  input  logic                  tcam_drop_i,
  input  logic                  class_drop_i,
  input  logic                  l2_match_i,
  input  logic                  bad_csum_i,
  input  logic [TCP_FLAG_W-1:0] tcp_flags_i,
  input  logic                  vlan_perr_i,
  input  logic [VLAN_AW-1:0]    vlan_perr_addr_i,
  input  logic                  tcam_perr_i,
  input  logic [TCAM_AW-1:0]    tcam_perr_addr_i,
  input  logic                  reg_wr_i,
  input  logic                  reg_rd_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  output logic                  drop_o,
  output logic                  irq_o
);
  localparam int TCAM_LSB = 16;
  localparam int TCFG_W   = TCP_FLAG_W + 1;

  logic [NUM_ST-1:0]  status_q, status_d, irq_mask_q, w1c, dbg_set, set_evt;
  logic [NUM_RSN-1:0] log_mask_q, rsn, drop_log;
  logic [TCFG_W-1:0]  tcp_cfg_q;
  logic               tcp_hit, drop_cap;
  logic [VLAN_AW-1:0] vlan_log;
  logic [TCAM_AW-1:0] tcam_log;
  logic [NUM_CNT-1:0] cnt_inc, cnt_clr;
  logic [CNT_W-1:0]   cnt_val [NUM_CNT];
  logic [DATA_W-1:0]  rd_mux, rdata_q;
  logic               wr_st, wr_dbg, wr_imsk, wr_lmsk, wr_tcp;
  logic               unused_wdata;

  assign unused_wdata = ^reg_wdata_i;

  assign wr_st   = reg_wr_i && reg_addr_i == ADDR_W'(RA_STATUS);
  assign wr_dbg  = reg_wr_i && reg_addr_i == ADDR_W'(RA_DEBUG);
  assign wr_imsk = reg_wr_i && reg_addr_i == ADDR_W'(RA_IRQMSK);
  assign wr_lmsk = reg_wr_i && reg_addr_i == ADDR_W'(RA_LOGMSK);
  assign wr_tcp  = reg_wr_i && reg_addr_i == ADDR_W'(RA_TCPCFG);

  pdm_tcp_check #(.FLAG_W(TCP_FLAG_W)) u_tcp (
    .flags_i   (tcp_flags_i),
    .mask_i    (tcp_cfg_q[TCP_FLAG_W-1:0]),
    .discard_i (tcp_cfg_q[TCP_FLAG_W]),
    .hit_o     (tcp_hit)
  );

  always_comb begin
    rsn           = '0;
    rsn[RSN_VLAN] = vlan_miss_i;
    rsn[RSN_TCAM] = tcam_drop_i;
    rsn[RSN_CLS]  = class_drop_i;
    rsn[RSN_L2]   = ~l2_match_i;
    rsn[RSN_TCP]  = tcp_hit;
  end

  assign drop_o   = pkt_valid_i & (|rsn);
  assign drop_cap = pkt_valid_i & (|(rsn & ~log_mask_q));

  // Status: W1C and debug set; hardware events win over a clear
  assign w1c     = wr_st  ? reg_wdata_i[NUM_ST-1:0] : '0;
  assign dbg_set = wr_dbg ? reg_wdata_i[NUM_ST-1:0] : '0;
  always_comb begin
    set_evt               = '0;
    set_evt[ST_VLAN_PERR] = vlan_perr_i;
    set_evt[ST_TCAM_PERR] = tcam_perr_i;
    set_evt[ST_DROP]      = drop_cap & ~status_q[ST_DROP];
  end
  assign status_d = (status_q & ~w1c) | set_evt | dbg_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q   <= '0;
      irq_mask_q <= '0;
      log_mask_q <= '0;
      tcp_cfg_q  <= '0;
    end else begin
      status_q <= status_d;
      if (wr_imsk) irq_mask_q <= reg_wdata_i[NUM_ST-1:0];
      if (wr_lmsk) log_mask_q <= reg_wdata_i[NUM_RSN-1:0];
      if (wr_tcp)  tcp_cfg_q  <= reg_wdata_i[TCFG_W-1:0];
    end
  end

  assign irq_o = |(status_q & ~irq_mask_q);

  pdm_first_log #(.W(NUM_RSN)) u_drop_log (
    .clk_i, .rst_ni,
    .cap_i   (drop_cap),
    .armed_i (~status_q[ST_DROP]),
    .clr_i   (w1c[ST_DROP]),
    .data_i  (rsn & ~log_mask_q),
    .log_o   (drop_log)
  );

  pdm_first_log #(.W(VLAN_AW)) u_vlan_log (
    .clk_i, .rst_ni,
    .cap_i   (vlan_perr_i),
    .armed_i (~status_q[ST_VLAN_PERR]),
    .clr_i   (w1c[ST_VLAN_PERR]),
    .data_i  (vlan_perr_addr_i),
    .log_o   (vlan_log)
  );

  pdm_first_log #(.W(TCAM_AW)) u_tcam_log (
    .clk_i, .rst_ni,
    .cap_i   (tcam_perr_i),
    .armed_i (~status_q[ST_TCAM_PERR]),
    .clr_i   (w1c[ST_TCAM_PERR]),
    .data_i  (tcam_perr_addr_i),
    .log_o   (tcam_log)
  );

  // Counters gated on address match: 0 = drops, 1 = bad checksums
  assign cnt_inc[0] = drop_o & l2_match_i;
  assign cnt_inc[1] = pkt_valid_i & l2_match_i & bad_csum_i;
  assign cnt_clr[0] = reg_rd_i && reg_addr_i == ADDR_W'(RA_DCNT);
  assign cnt_clr[1] = reg_rd_i && reg_addr_i == ADDR_W'(RA_BCNT);

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    pdm_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk_i, .rst_ni,
      .inc_i (cnt_inc[g]),
      .clr_i (cnt_clr[g]),
      .cnt_o (cnt_val[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr_i)
      ADDR_W'(RA_STATUS): rd_mux[NUM_ST-1:0]  = status_q;
      ADDR_W'(RA_IRQMSK): rd_mux[NUM_ST-1:0]  = irq_mask_q;
      ADDR_W'(RA_LOGMSK): rd_mux[NUM_RSN-1:0] = log_mask_q;
      ADDR_W'(RA_TCPCFG): rd_mux[TCFG_W-1:0]  = tcp_cfg_q;
      ADDR_W'(RA_LOG):    rd_mux[NUM_RSN-1:0] = drop_log;
      ADDR_W'(RA_PERR): begin
        rd_mux[VLAN_AW-1:0]                 = vlan_log;
        rd_mux[TCAM_LSB+TCAM_AW-1:TCAM_LSB] = tcam_log;
      end
      ADDR_W'(RA_DCNT):   rd_mux[CNT_W-1:0]   = cnt_val[0];
      ADDR_W'(RA_BCNT):   rd_mux[CNT_W-1:0]   = cnt_val[1];
      default:            rd_mux              = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (reg_rd_i) rdata_q <= rd_mux;
  end

  assign reg_rdata_o = rdata_q;

  p_l2_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && !l2_match_i && !cnt_clr[0]) |=> $stable(cnt_val[0]));
  p_w1c_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_st && reg_wdata_i[ST_DROP] && !drop_cap) |=> !status_q[ST_DROP]);
  p_dbg_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dbg |=> ((status_q & $past(reg_wdata_i[NUM_ST-1:0])) == $past(reg_wdata_i[NUM_ST-1:0])));
  p_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_cap && !status_q[ST_DROP]) |=> status_q[ST_DROP]);
endmodule

// File: tb/pkt_drop_monitor_tb_top.sv
module pkt_drop_monitor_tb_top;
  localparam int CW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 0, rst_ni = 0;
  logic pkt_valid = 0, vlan_miss = 0, tcam_drop = 0, class_drop = 0, l2_match = 0, bad_csum = 0;
  logic [5:0] tcp_flags = 0;
  logic vlan_perr = 0, tcam_perr = 0;
  logic [11:0] vlan_perr_addr = 0;
  logic [7:0] tcam_perr_addr = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic drop, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic [2:0] m_st = 0, m_imsk = 0;
  logic [4:0] m_lmsk = 0, m_log = 0;
  logic [6:0] m_tcp = 0;
  logic [11:0] m_vlog = 0;
  logic [7:0] m_tlog = 0;
  int m_dcnt = 0, m_bcnt = 0;

  always #10 clk = ~clk;

  pkt_drop_monitor #(.CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .pkt_valid_i(pkt_valid), .vlan_miss_i(vlan_miss),
    .tcam_drop_i(tcam_drop), .class_drop_i(class_drop), .l2_match_i(l2_match),
    .bad_csum_i(bad_csum), .tcp_flags_i(tcp_flags), .vlan_perr_i(vlan_perr),
    .vlan_perr_addr_i(vlan_perr_addr), .tcam_perr_i(tcam_perr), .tcam_perr_addr_i(tcam_perr_addr),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .drop_o(drop), .irq_o(irq)
  );

  function automatic logic [4:0] reasons(logic v, logic t, logic c, logic l2, logic [5:0] fl, logic [6:0] cfg);
    logic tcp_r = cfg[6] & (|(fl & cfg[5:0]));
    return {tcp_r, ~l2, c, t, v};
  endfunction

  function automatic int sat_inc(int v);
    return (v >= CMAX) ? CMAX : v + 1;
  endfunction

  function automatic logic [31:0] exp_reg(int a);
    case (a)
      0: return {29'd0, m_st};
      2: return {29'd0, m_imsk};
      3: return {27'd0, m_lmsk};
      4: return {25'd0, m_tcp};
      5: return {27'd0, m_log};
      6: return {8'd0, m_tlog, 4'd0, m_vlog};
      7: return 32'(m_dcnt);
      8: return 32'(m_bcnt);
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wreg(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = 4'(a); reg_wdata = d;
    @(posedge clk);
    case (a)
      0: begin
        m_st = m_st & ~d[2:0];
        if (d[0]) m_vlog = 0;
        if (d[1]) m_tlog = 0;
        if (d[2]) m_log = 0;
      end
      1: m_st = m_st | d[2:0];
      2: m_imsk = d[2:0];
      3: m_lmsk = d[4:0];
      4: m_tcp = d[6:0];
      default: ;
    endcase
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rchk(input int a, input string req);
    logic [31:0] e;
    @(negedge clk);
    reg_rd = 1; reg_addr = 4'(a);
    e = exp_reg(a);
    @(posedge clk);
    if (a == 7) m_dcnt = 0;
    if (a == 8) m_bcnt = 0;
    @(negedge clk);
    reg_rd = 0;
    chk(reg_rdata == e, req, $sformatf("reg %0d", a), reg_rdata, e);
  endtask

  task automatic model_pkt(input logic [4:0] rs, input logic l2, input logic bad);
    if (l2 && |rs) m_dcnt = sat_inc(m_dcnt);
    if (l2 && bad) m_bcnt = sat_inc(m_bcnt);
    if (!m_st[2] && |(rs & ~m_lmsk)) begin
      m_log = rs & ~m_lmsk;
      m_st[2] = 1;
    end
  endtask

  task automatic send(input logic v, t, c, l2, bad, input logic [5:0] fl, input string req);
    logic [4:0] rs;
    @(negedge clk);
    pkt_valid = 1; vlan_miss = v; tcam_drop = t; class_drop = c;
    l2_match = l2; bad_csum = bad; tcp_flags = fl;
    rs = reasons(v, t, c, l2, fl, m_tcp);
    #1;
    chk(drop == (|rs), req, "drop_o", 32'(drop), 32'(|rs));
    @(posedge clk);
    model_pkt(rs, l2, bad);
    @(negedge clk);
    pkt_valid = 0; vlan_miss = 0; tcam_drop = 0; class_drop = 0;
    l2_match = 0; bad_csum = 0; tcp_flags = 0;
  endtask

  task automatic perr(input bit is_tcam, input logic [11:0] a);
    @(negedge clk);
    if (is_tcam) begin tcam_perr = 1; tcam_perr_addr = a[7:0]; end
    else begin vlan_perr = 1; vlan_perr_addr = a; end
    @(posedge clk);
    if (is_tcam) begin if (!m_st[1]) m_tlog = a[7:0]; m_st[1] = 1; end
    else begin if (!m_st[0]) m_vlog = a; m_st[0] = 1; end
    @(negedge clk);
    vlan_perr = 0; tcam_perr = 0;
  endtask

  task automatic irq_chk(input string req);
    logic e = |(m_st & ~m_imsk);
    @(negedge clk);
    chk(irq == e, req, "irq_o", 32'(irq), 32'(e));
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R12 reset state
    irq_chk("R12");
    for (int a = 0; a <= 8; a++) rchk(a, "R12");

    // R1 / R3 / R7 first capture
    send(0, 0, 0, 1, 0, 6'h00, "R1");
    send(1, 0, 0, 1, 0, 6'h00, "R1");
    rchk(5, "R3");
    rchk(0, "R3");
    irq_chk("R7");
    // R4 frozen then re-arm
    send(0, 0, 1, 1, 0, 6'h00, "R4");
    send(0, 1, 0, 0, 0, 6'h00, "R4");
    rchk(5, "R4");
    wreg(0, 32'h4);
    rchk(5, "R4");
    rchk(0, "R5");
    send(0, 0, 1, 1, 0, 6'h00, "R4");
    rchk(5, "R4");
    wreg(0, 32'h4);

    // R2 TCP control: SYN masked in, discard on
    wreg(4, 32'h50);
    send(0, 0, 0, 1, 0, 6'h10, "R2");
    rchk(5, "R2");
    send(0, 0, 0, 1, 0, 6'h02, "R2");
    wreg(4, 32'h10);
    send(0, 0, 0, 1, 0, 6'h3f, "R2");
    wreg(0, 32'h4);

    // R3 log mask excludes VLAN
    wreg(3, 32'h01);
    send(1, 0, 0, 1, 0, 6'h00, "R3");
    rchk(0, "R3");
    rchk(5, "R3");
    send(1, 1, 0, 1, 0, 6'h00, "R3");
    rchk(5, "R3");
    wreg(0, 32'h4);
    wreg(3, 32'h00);

    // R6 debug set, R7 mask
    wreg(1, 32'h1);
    rchk(0, "R6");
    irq_chk("R7");
    wreg(2, 32'h7);
    irq_chk("R7");
    rchk(2, "R7");
    wreg(2, 32'h0);
    wreg(0, 32'h7);
    irq_chk("R5");

    // R8 parity logs
    perr(0, 12'hABC);
    perr(0, 12'h123);
    perr(1, 12'h05A);
    rchk(6, "R8");
    perr(1, 12'h0C3);
    rchk(6, "R8");
    wreg(0, 32'h1);
    rchk(6, "R8");
    wreg(0, 32'h2);
    rchk(6, "R8");

    // R9 gating on address match
    rchk(7, "R9"); rchk(8, "R9");
    send(1, 0, 0, 0, 1, 6'h00, "R9");
    send(0, 0, 0, 0, 0, 6'h00, "R9");
    send(0, 0, 0, 1, 1, 6'h00, "R9");
    send(0, 1, 0, 1, 0, 6'h00, "R9");
    rchk(7, "R9"); rchk(8, "R9");
    wreg(0, 32'h4);

    // R10 read colliding with increment
    send(0, 1, 0, 1, 0, 6'h00, "R10");
    send(0, 1, 0, 1, 0, 6'h00, "R10");
    @(negedge clk);
    pkt_valid = 1; tcam_drop = 1; l2_match = 1; reg_rd = 1; reg_addr = 4'd7;
    @(posedge clk);
    @(negedge clk);
    pkt_valid = 0; tcam_drop = 0; l2_match = 0; reg_rd = 0;
    chk(reg_rdata == 32'd2, "R10", "read with inc", reg_rdata, 32'd2);
    m_dcnt = 1;
    rchk(7, "R10");
    rchk(7, "R10");
    wreg(0, 32'h4);

    // R11 saturation
    for (int i = 0; i < 20; i++) send(0, 0, 1, 1, 1, 6'h00, "R11");
    rchk(7, "R11"); rchk(8, "R11");

    // random phase
    wreg(4, 32'h40 | ($urandom % 64));
    wreg(3, $urandom % 32);
    for (int i = 0; i < 400; i++) begin
      send(($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 5) == 0,
           ($urandom % 4) != 0, ($urandom % 3) == 0, 6'($urandom), "R1");
      if (i % 25 == 24) begin
        rchk(5, "R3");
        rchk(0, "R5");
        irq_chk("R7");
        rchk(7, "R9");
        rchk(8, "R9");
        if ($urandom % 2) wreg(0, 32'h4);
        if (i % 100 == 99) wreg(3, $urandom % 32);
      end
    end

    done = 1;
    summary();
    $finish;
  end
endmodule